// File: doc/BRIEF.md
# Serial Flash Command and Address Front End

This block sits behind the shift register of a serial NOR flash slave. It receives whole command bytes that have already been deserialised, framed by an active-low chip select. The first byte of each selection is the opcode, which the block sorts into a class: read, program, erase, bank-register write, or unsupported. For the three addressed classes the block collects the address bytes that follow, most significant first. It then builds a 32-bit array address. In the default 3-byte mode, a volatile bank register supplies the top byte and the host sends the lower 24 bits. Bit 7 of the same register is an extended-address enable. When it is set, every addressed opcode takes a full 4-byte address instead.

After a read address is formed, a counter tracks the running read address. It moves forward by one for each advance request and crosses 16-Mbyte bank boundaries without a pause. It never writes back into the bank register. At the last array location it raises an end-of-array flag and stops. Byte input is a valid/ready stream with a simple back-pressure rule. Ready is high for the whole time chip select is low and low whenever it is high, so the block never stalls a selected transfer. A byte moves on any clock edge where valid and ready are both high.

Top module: `flash_addr_front`

## Requirements
- R1: After reset, bank_q is 0x00, so 3-byte mode and bank 0 are selected. op_class is 0, start_vld is 0, rd_addr is 0 and eoa is 0.
- R2: The first byte of a selection sets op_class. The value appears in the cycle after that byte is accepted and holds until chip select rises, after which op_class is 0. The codes are as follows. Read (1): 0x03, 0x0B, 0x3B, 0x6B, 0xBB, 0xEB, 0x0D, 0xBD, 0xED. Program (2): 0x02, 0x32. Erase (3): 0x20, 0xD8. Bank write (4): 0x17. Any other byte is unsupported (5).
- R3: When bank_q bit 7 is 0, an addressed opcode takes 3 address bytes, most significant first. start_vld pulses for exactly one cycle, the cycle after the last byte. start_addr is {bank_q & 0x03, byte0, byte1, byte2}.
- R4: When bank_q bit 7 is 1, every addressed opcode in R2 takes 4 bytes, and start_addr is the 32 received bits unchanged.
- R5: Opcode 0x17 loads the next byte into the bank register, keeping only bits 7 and 1:0; the other bits read 0. The load takes effect at the clock edge where chip select is sampled high after the data byte. A selection that ends before the data byte leaves bank_q unchanged.
- R6: Program and erase opcodes form start_addr by the same rules as reads, including the bank top byte.
- R7: A read start address is loaded into the counter one cycle after start_vld, truncated to the array size (32 Mbyte by default). Each later cycle with rd_adv high adds one, with no extra cycle at a bank boundary.
- R8: bank_q never changes while chip select stays low. A read that crosses a bank boundary leaves bank_q unchanged.
- R9: While a read is active and rd_addr equals the last array address (0x01FFFFFF by default), eoa is 1 and rd_addr holds its value even when rd_adv is high.
- R10: After an unsupported opcode, every byte is ignored until chip select rises: start_vld stays 0 and bank_q is unchanged.
- R11: in_ready equals the inverse of cs_n. A cycle with in_valid low does not advance byte collection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select framing a command |
| in_valid | input | 1 | Byte stream valid |
| in_ready | output | 1 | Byte stream ready (high while selected) |
| in_byte | input | 8 | Received command/address/data byte |
| rd_adv | input | 1 | Request to step the read address |
| op_class | output | 3 | Opcode class of the current selection |
| start_vld | output | 1 | One-cycle pulse: start_addr is new |
| start_addr | output | 32 | Formed starting array address |
| rd_addr | output | 32 | Running read address |
| eoa | output | 1 | Read reached the last array location |
| bank_q | output | 8 | Bank register contents |

## Verification
Each result falls due a fixed number of cycles after its stimulus. op_class and start_vld/start_addr appear the cycle after the byte that causes them. rd_addr appears one cycle after that, and each step follows the advancing edge directly. A bank-register load becomes visible the cycle after chip select is sampled high. The bench drives inputs on the falling edge and samples 1 ns after the next rising edge. It waits an explicit extra cycle before reading rd_addr, so every check reads the exact cycle its result is due.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;

  localparam int ADDR_W  = 32;
  localparam int EXT_BIT = 7;

  typedef enum logic [2:0] {
    OPC_NONE   = 3'd0,
    OPC_READ   = 3'd1,
    OPC_PROG   = 3'd2,
    OPC_ERASE  = 3'd3,
    OPC_BANKWR = 3'd4,
    OPC_OTHER  = 3'd5
  } opc_class_e;

  function automatic opc_class_e classify_op(input logic [7:0] op,
                                             input logic [7:0] bank_op);
    opc_class_e c;
    if (op == bank_op) begin
      c = OPC_BANKWR;
    end else begin
      case (op)
        8'h03, 8'h0B, 8'h3B, 8'h6B, 8'hBB,
        8'hEB, 8'h0D, 8'hBD, 8'hED:          c = OPC_READ;
        8'h02, 8'h32:                        c = OPC_PROG;
        8'h20, 8'hD8:                        c = OPC_ERASE;
        default:                             c = OPC_OTHER;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/flash_op_decode.sv
module flash_op_decode
  import flash_fe_pkg::*;
#(
  parameter logic [7:0] BANK_WR_OP = 8'h17
) (
  input  logic [7:0]  op_byte,
  output opc_class_e  op_cls,
  output logic        addr_cmd
);

  always_comb begin
    op_cls   = classify_op(op_byte, BANK_WR_OP);
    addr_cmd = (op_cls == OPC_READ) || (op_cls == OPC_PROG) ||
               (op_cls == OPC_ERASE);
  end

endmodule

// File: rtl/flash_bank_reg.sv
module flash_bank_reg
  import flash_fe_pkg::*;
#(
  parameter int BANK_BITS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] bank_q,
  output logic       ext_mode,
  output logic [7:0] bank_byte
);

  localparam logic [7:0] SEL_MASK  = 8'((1 << BANK_BITS) - 1);
  localparam logic [7:0] KEEP_MASK = SEL_MASK | (8'h1 << EXT_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bank_q <= 8'h00;
    else if (wr_en) bank_q <= wr_data & KEEP_MASK;
  end

  assign ext_mode  = bank_q[EXT_BIT];
  assign bank_byte = bank_q & SEL_MASK;

endmodule

// File: rtl/flash_addr_collect.sv
module flash_addr_collect
  import flash_fe_pkg::*;
#(
  parameter logic [7:0] BANK_WR_OP = 8'h17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_byte,
  input  logic              ext_mode,
  input  logic [7:0]        bank_byte,
  output opc_class_e        op_class,
  output logic              start_vld,
  output logic [ADDR_W-1:0] start_addr,
  output logic              bank_wr_en,
  output logic [7:0]        bank_wr_data
);

  typedef enum logic [2:0] {
    ST_OP, ST_ADDR, ST_BDATA, ST_BFULL, ST_SKIP
  } col_state_e;

  col_state_e  state;
  logic [1:0]  cnt;
  logic        four_b;
  logic [23:0] shreg;
  logic [7:0]  pend;
  opc_class_e  dec_cls;
  logic        dec_addr;
  logic        take;
  logic [1:0]  last_idx;

  flash_op_decode #(.BANK_WR_OP(BANK_WR_OP)) dec_i (
    .op_byte  (in_byte),
    .op_cls   (dec_cls),
    .addr_cmd (dec_addr)
  );

  assign in_ready = !cs_n;
  assign take     = in_valid && in_ready;
  assign last_idx = four_b ? 2'd3 : 2'd2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_OP;
      cnt        <= '0;
      four_b     <= 1'b0;
      shreg      <= '0;
      pend       <= '0;
      op_class   <= OPC_NONE;
      start_vld  <= 1'b0;
      start_addr <= '0;
    end else if (cs_n) begin
      state     <= ST_OP;
      cnt       <= '0;
      op_class  <= OPC_NONE;
      start_vld <= 1'b0;
    end else begin
      start_vld <= 1'b0;
      if (take) begin
        case (state)
          ST_OP: begin
            op_class <= dec_cls;
            cnt      <= '0;
            four_b   <= ext_mode;
            if (dec_addr)                  state <= ST_ADDR;
            else if (dec_cls == OPC_BANKWR) state <= ST_BDATA;
            else                           state <= ST_SKIP;
          end
          ST_ADDR: begin
            shreg <= {shreg[15:0], in_byte};
            cnt   <= cnt + 2'd1;
            if (cnt == last_idx) begin
              start_vld  <= 1'b1;
              start_addr <= four_b ? {shreg, in_byte}
                                   : {bank_byte, shreg[15:0], in_byte};
              state      <= ST_SKIP;
            end
          end
          ST_BDATA: begin
            pend  <= in_byte;
            state <= ST_BFULL;
          end
          default: ;
        endcase
      end
    end
  end

  assign bank_wr_en   = cs_n && (state == ST_BFULL);
  assign bank_wr_data = pend;

  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_vld |=> !start_vld);

  // R2
  class_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (op_class == OPC_NONE) && !start_vld);

endmodule

// File: rtl/flash_rd_counter.sv
module flash_rd_counter
  import flash_fe_pkg::*;
#(
  parameter int ARRAY_AW = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              adv,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              eoa
);

  localparam logic [ARRAY_AW-1:0] LAST = '1;

  logic [ARRAY_AW-1:0] cnt;
  logic                active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (load) begin
      cnt    <= load_addr[ARRAY_AW-1:0];
      active <= 1'b1;
    end else if (cs_n) begin
      active <= 1'b0;
    end else if (active && adv && (cnt != LAST)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign rd_addr = ADDR_W'(cnt);
  assign eoa     = active && (cnt == LAST);

  // R7
  adv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active && adv && !eoa && !load && !cs_n |=> rd_addr == $past(rd_addr) + 32'd1);

  // R9
  eoa_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoa && !load |=> $stable(rd_addr));

endmodule

// File: rtl/flash_addr_front.sv
module flash_addr_front
  import flash_fe_pkg::*;
#(
  parameter int         ARRAY_AW   = 25,
  parameter int         BANK_BITS  = 2,
  parameter logic [7:0] BANK_WR_OP = 8'h17
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_byte,
  input  logic        rd_adv,
  output logic [2:0]  op_class,
  output logic        start_vld,
  output logic [31:0] start_addr,
  output logic [31:0] rd_addr,
  output logic        eoa,
  output logic [7:0]  bank_q
);

  localparam logic [7:0] SEL_MASK = 8'((1 << BANK_BITS) - 1);

  opc_class_e cls;
  logic       ext_mode;
  logic [7:0] bank_byte;
  logic       bank_wr_en;
  logic [7:0] bank_wr_data;
  logic       rd_load;

  flash_bank_reg #(.BANK_BITS(BANK_BITS)) bank_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (bank_wr_en),
    .wr_data   (bank_wr_data),
    .bank_q    (bank_q),
    .ext_mode  (ext_mode),
    .bank_byte (bank_byte)
  );

  flash_addr_collect #(.BANK_WR_OP(BANK_WR_OP)) col_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (cs_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_byte      (in_byte),
    .ext_mode     (ext_mode),
    .bank_byte    (bank_byte),
    .op_class     (cls),
    .start_vld    (start_vld),
    .start_addr   (start_addr),
    .bank_wr_en   (bank_wr_en),
    .bank_wr_data (bank_wr_data)
  );

  assign rd_load  = start_vld && (cls == OPC_READ);
  assign op_class = cls;

  flash_rd_counter #(.ARRAY_AW(ARRAY_AW)) cnt_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .load      (rd_load),
    .load_addr (start_addr),
    .adv       (rd_adv),
    .rd_addr   (rd_addr),
    .eoa       (eoa)
  );

  // R8
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n && !$past(cs_n) |-> $stable(bank_q));

  // R3
  top_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_vld && !bank_q[EXT_BIT] |-> start_addr[31:24] == (bank_q & SEL_MASK));

endmodule

// File: tb/flash_addr_front_tb.sv
`timescale 1ns/1ps
module flash_addr_front_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_byte = 8'h00;
  logic        rd_adv = 1'b0;
  logic [2:0]  op_class;
  logic        start_vld;
  logic [31:0] start_addr;
  logic [31:0] rd_addr;
  logic        eoa;
  logic [7:0]  bank_q;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  flash_addr_front dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_byte    (in_byte),
    .rd_adv     (rd_adv),
    .op_class   (op_class),
    .start_vld  (start_vld),
    .start_addr (start_addr),
    .rd_addr    (rd_addr),
    .eoa        (eoa),
    .bank_q     (bank_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    cs_n = 1'b0; in_valid = 1'b1; in_byte = b; rd_adv = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic tick;
    @(negedge clk);
    in_valid = 1'b0; rd_adv = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic adv;
    @(negedge clk);
    in_valid = 1'b0; rd_adv = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic deselect;
    @(negedge clk);
    cs_n = 1'b1; in_valid = 1'b0; rd_adv = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic write_bank(input logic [7:0] v);
    put(8'h17); put(v); deselect();
  endtask

  task automatic t_reset;
    chk("R1 bank_q", 32'(bank_q), 0);
    chk("R1 op_class", 32'(op_class), 0);
    chk("R1 start_vld", 32'(start_vld), 0);
    chk("R1 rd_addr", rd_addr, 0);
    chk("R1 eoa", 32'(eoa), 0);
  endtask

  task automatic t_classes;
    logic [7:0] ops [15] = '{8'h03, 8'h0B, 8'h3B, 8'h6B, 8'hBB, 8'hEB, 8'h0D,
                             8'hBD, 8'hED, 8'h02, 8'h32, 8'h20, 8'hD8, 8'h17, 8'h9F};
    logic [2:0] cls [15] = '{3'd1, 3'd1, 3'd1, 3'd1, 3'd1, 3'd1, 3'd1,
                             3'd1, 3'd1, 3'd2, 3'd2, 3'd3, 3'd3, 3'd4, 3'd5};
    for (int i = 0; i < 15; i++) begin
      put(ops[i]);
      chk("R2 class", 32'(op_class), 32'(cls[i]));
      deselect();
    end
    chk("R2 cleared", 32'(op_class), 0);
    chk("R5 aborted bank write", 32'(bank_q), 0);
  endtask

  task automatic t_read3;
    put(8'h03); put(8'h12); put(8'h34);
    chk("R3 no early start", 32'(start_vld), 0);
    put(8'h56);
    chk("R3 start_vld", 32'(start_vld), 1);
    chk("R3 start_addr", start_addr, 32'h0012_3456);
    tick();
    chk("R3 pulse width", 32'(start_vld), 0);
    chk("R7 rd load", rd_addr, 32'h0012_3456);
    adv();
    chk("R7 step", rd_addr, 32'h0012_3457);
    deselect();
  endtask

  task automatic t_bank1_eoa;
    write_bank(8'h01);
    chk("R5 bank load", 32'(bank_q), 32'h01);
    put(8'h0B); put(8'hFF); put(8'hFF); put(8'hFE);
    chk("R3 bank1 start", start_addr, 32'h01FF_FFFE);
    tick();
    chk("R9 no eoa yet", 32'(eoa), 0);
    adv();
    chk("R9 last addr", rd_addr, 32'h01FF_FFFF);
    chk("R9 eoa set", 32'(eoa), 1);
    adv(); adv();
    chk("R9 hold", rd_addr, 32'h01FF_FFFF);
    chk("R9 eoa stays", 32'(eoa), 1);
    deselect();
  endtask

  task automatic t_cross;
    write_bank(8'h00);
    put(8'h03); put(8'hFF); put(8'hFF); put(8'hFF);
    tick();
    chk("R7 cross start", rd_addr, 32'h00FF_FFFF);
    adv();
    chk("R7 cross no gap", rd_addr, 32'h0100_0000);
    adv();
    chk("R7 after cross", rd_addr, 32'h0100_0001);
    chk("R8 bank unchanged in read", 32'(bank_q), 0);
    deselect();
    chk("R8 bank unchanged after", 32'(bank_q), 0);
  endtask

  task automatic t_ext;
    write_bank(8'h80);
    chk("R4 ext bit", 32'(bank_q), 32'h80);
    put(8'h0B); put(8'h01); put(8'h00); put(8'h00);
    chk("R4 needs fourth byte", 32'(start_vld), 0);
    put(8'h10);
    chk("R4 start_vld", 32'(start_vld), 1);
    chk("R4 read addr", start_addr, 32'h0100_0010);
    deselect();
    put(8'h02); put(8'hAB); put(8'hCD); put(8'hEF); put(8'h01);
    chk("R4 prog addr", start_addr, 32'hABCD_EF01);
    deselect();
    put(8'hD8); put(8'h00); put(8'h00); put(8'h00);
    chk("R4 erase waits", 32'(start_vld), 0);
    put(8'h07);
    chk("R4 erase addr", start_addr, 32'h0000_0007);
    deselect();
  endtask

  task automatic t_mask_prog;
    write_bank(8'hFE);
    chk("R5 mask", 32'(bank_q), 32'h82);
    write_bank(8'h02);
    chk("R5 reload", 32'(bank_q), 32'h02);
    put(8'h32); put(8'h00); put(8'h00); put(8'h01);
    chk("R6 prog bank", start_addr, 32'h0200_0001);
    deselect();
    put(8'h20); put(8'h12); put(8'h00); put(8'h00);
    chk("R6 erase bank", start_addr, 32'h0212_0000);
    deselect();
    put(8'h17);
    deselect();
    chk("R5 aborted keeps", 32'(bank_q), 32'h02);
  endtask

  task automatic t_other;
    put(8'h9F);
    chk("R10 class", 32'(op_class), 5);
    put(8'h03); chk("R10 no start a", 32'(start_vld), 0);
    put(8'h17); chk("R10 no start b", 32'(start_vld), 0);
    put(8'h81); chk("R10 no start c", 32'(start_vld), 0);
    put(8'h00); chk("R10 no start d", 32'(start_vld), 0);
    deselect();
    chk("R10 bank kept", 32'(bank_q), 32'h02);
  endtask

  task automatic t_ready;
    chk("R11 ready low deselected", 32'(in_ready), 0);
    put(8'h03);
    chk("R11 ready high selected", 32'(in_ready), 1);
    tick();
    put(8'hAA); tick(); tick();
    put(8'hBB);
    chk("R11 gap no start", 32'(start_vld), 0);
    tick();
    put(8'hCC);
    chk("R11 gap start", start_addr, 32'h02AA_BBCC);
    deselect();
    chk("R11 ready low again", 32'(in_ready), 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_classes();
    t_read3();
    t_bank1_eoa();
    t_cross();
    t_ext();
    t_mask_prog();
    t_other();
    t_ready();
    finish_run();
  end

endmodule